// File: doc/BRIEF.md
# Command-Driven Up/Down Timer/Counter

A single-channel timer/counter that advances once per prescaled tick and is steered through a small register port. A control register uses write-one-to-set semantics and holds three flags and a pending command code. The flags are direction, one-shot and update lock. A companion address clears the flags with write-one-to-clear semantics. Software posts a command, such as restart, halt, forced buffer load or count snapshot. The command is carried out on the next tick, and its code then reads back as zero.

Period and compare values are double-buffered. Software writes the buffers. The active copies take the buffered values at each counter wrap, which is the hardware update point, or when a forced load is commanded. The lock flag suppresses the copy at the wrap so that several buffers can be rewritten consistently. The lock is ignored while the capture-mode input is high. The live count is not read directly: a snapshot command latches it into a readable register. Overflow and underflow events are single-cycle pulses, and a running flag shows whether the counter is stepping.

Top module: `cmd_timer`

## Requirements
- R1: After reset, the direction, lock and one-shot flags, the pending command, the live count and the snapshot are all zero, and running is low. The active period and its buffer hold PER_RST (all ones by default). The active compare value and its buffer are zero.
- R2: Address 0 is the set address. A write there with a nonzero value in wdata[6:4] posts that code as the pending command: 1 restart, 2 halt, 3 forced load, 4 snapshot, and 5 to 7 do nothing. The pending code reads back in rdata[6:4] at addresses 0 and 1. It is executed on the first tick in a cycle after the write, and from then on it reads zero. A nonzero write in the same cycle as a tick stays pending.
- R3: At address 0, writing 1 to wdata[0], wdata[1] or wdata[2] sets the direction, lock or one-shot flag. At address 1, writing 1 to those bits clears the flags. Zero bits, and a zero command field, leave the state unchanged. The flags read back in rdata[2:0].
- R4: A restart sets the count to 0 when counting up, or to the active period when counting down. It sets running, whatever the counter's previous state.
- R5: A halt clears running and keeps the count. Later ticks do not change the count until the next restart.
- R6: With direction 0, each tick while running adds one to the count. At the tick where the count equals the active period, the count goes to 0 and ovf_evt is high for exactly the next cycle.
- R7: With direction 1, each tick while running takes one from the count. At the tick where the count is 0, the counter reloads the period and unf_evt is high for exactly the next cycle.
- R8: With one-shot set, running clears at the wrap. With one-shot clear, counting continues after the wrap.
- R9: At a wrap, the active period (address 4) and active compare (address 5) take the values of their buffers (addresses 2 and 3) unless lock is 1 and capture_en is 0. A down reload uses the new period whenever this copy happens.
- R10: A forced load copies both buffers into the active registers whatever the lock and capture_en values.
- R11: Address 6 returns the snapshot, which changes only when a snapshot command is executed. It then holds the count as it was before that tick.
- R12: A tick that executes a command does not step the counter and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| tick | input | 1 | Prescaled counter tick, one cycle wide |
| capture_en | input | 1 | Capture mode active; overrides the lock |
| ovf_evt | output | 1 | Overflow pulse |
| unf_evt | output | 1 | Underflow pulse |
| running | output | 1 | Counter is stepping on ticks |

## Verification
Writes land at the rising edge of their cycle, so flags, buffers and the pending code are readable in the next cycle. Count, running, active registers and snapshot change at the edge of the tick cycle that acts on them, and the event pulses are high only in the cycle after that edge. The bench applies each stimulus for one rising edge and advances a reference model at that same edge. At the following falling edge, it compares running, both events and every readable address with the model, so each result is checked in the one cycle where it is first due.

// File: rtl/cmd_timer_pkg.sv
`timescale 1ns/100ps
package cmd_timer_pkg;

  typedef enum logic [2:0] {
    ADR_SET  = 3'd0,
    ADR_CLR  = 3'd1,
    ADR_PBUF = 3'd2,
    ADR_CBUF = 3'd3,
    ADR_PER  = 3'd4,
    ADR_CMP  = 3'd5,
    ADR_SNAP = 3'd6
  } tmr_addr_e;

  localparam logic [2:0] OP_NONE    = 3'd0;
  localparam logic [2:0] OP_RESTART = 3'd1;
  localparam logic [2:0] OP_HALT    = 3'd2;
  localparam logic [2:0] OP_LOAD    = 3'd3;
  localparam logic [2:0] OP_SNAP    = 3'd4;

  localparam int unsigned OP_LSB = 4;

  typedef struct packed {
    logic one_shot;
    logic lock;
    logic down;
  } tmr_flags_t;

endpackage

// File: rtl/tmr_ctrl_regs.sv
`timescale 1ns/100ps
module tmr_ctrl_regs
  import cmd_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [2:0] flag_bits,
  input  logic [2:0] op_bits,
  input  logic       tick,
  output tmr_flags_t flags,
  output logic [2:0] op_pend
);

  tmr_flags_t flags_q, flags_d;
  logic [2:0] op_q, op_d;
  logic       wr_set, wr_clr, flags_en, op_en, op_post;

  assign wr_set  = we && (addr == ADR_SET);
  assign wr_clr  = we && (addr == ADR_CLR);
  assign op_post = wr_set && (op_bits != OP_NONE);
  assign flags_en = wr_set || wr_clr;
  assign op_en    = tick || op_post;

  always_comb begin
    flags_d = flags_q;
    if (wr_set) begin
      if (flag_bits[0]) flags_d.down     = 1'b1;
      if (flag_bits[1]) flags_d.lock     = 1'b1;
      if (flag_bits[2]) flags_d.one_shot = 1'b1;
    end else if (wr_clr) begin
      if (flag_bits[0]) flags_d.down     = 1'b0;
      if (flag_bits[1]) flags_d.lock     = 1'b0;
      if (flag_bits[2]) flags_d.one_shot = 1'b0;
    end
  end

  always_comb begin
    op_d = op_q;
    if (tick)    op_d = OP_NONE;
    if (op_post) op_d = op_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= OP_NONE;
    else if (op_en) op_q <= op_d;
  end

  assign flags   = flags_q;
  assign op_pend = op_q;

  // R2
  op_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && op_q != OP_NONE && !op_post) |=> (op_q == OP_NONE));

  // R3
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && flag_bits[0]) |=> !flags_q.down);

endmodule

// File: rtl/tmr_bufs.sv
`timescale 1ns/100ps
module tmr_bufs
  import cmd_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter logic [DATA_W-1:0] PER_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              copy,
  output logic [DATA_W-1:0] per_buf,
  output logic [DATA_W-1:0] cmp_buf,
  output logic [DATA_W-1:0] per_act,
  output logic [DATA_W-1:0] cmp_act
);

  logic [DATA_W-1:0] pbuf_q, cbuf_q, per_q, cmp_q;
  logic pbuf_en, cbuf_en;

  assign pbuf_en = we && (addr == ADR_PBUF);
  assign cbuf_en = we && (addr == ADR_CBUF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pbuf_q <= PER_RST;
    else if (pbuf_en) pbuf_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cbuf_q <= '0;
    else if (cbuf_en) cbuf_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PER_RST;
      cmp_q <= '0;
    end else if (copy) begin
      per_q <= pbuf_q;
      cmp_q <= cbuf_q;
    end
  end

  assign per_buf = pbuf_q;
  assign cmp_buf = cbuf_q;
  assign per_act = per_q;
  assign cmp_act = cmp_q;

  // R9
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !copy |=> ($stable(per_q) && $stable(cmp_q)));

  // R9
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy |=> (per_q == $past(pbuf_q) && cmp_q == $past(cbuf_q)));

endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/100ps
module tmr_core
  import cmd_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        op,
  input  tmr_flags_t        flags,
  input  logic              capture_en,
  input  logic [DATA_W-1:0] per_act,
  input  logic [DATA_W-1:0] per_buf,
  output logic              copy,
  output logic [DATA_W-1:0] snap,
  output logic              running,
  output logic              ovf_evt,
  output logic              unf_evt
);

  logic [DATA_W-1:0] cnt_q, cnt_d, snap_q, snap_d;
  logic run_q, run_d, ovf_q, unf_q;
  logic exec, step, wrap_up, wrap_dn, wrap, hw_copy;

  assign exec    = tick && (op != OP_NONE);
  assign step    = tick && (op == OP_NONE) && run_q;
  assign wrap_up = step && !flags.down && (cnt_q == per_act);
  assign wrap_dn = step &&  flags.down && (cnt_q == '0);
  assign wrap    = wrap_up || wrap_dn;
  assign hw_copy = wrap && (!flags.lock || capture_en);
  assign copy    = hw_copy || (exec && op == OP_LOAD);

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    snap_d = snap_q;
    if (exec) begin
      case (op)
        OP_RESTART: begin
          cnt_d = flags.down ? per_act : '0;
          run_d = 1'b1;
        end
        OP_HALT: run_d  = 1'b0;
        OP_SNAP: snap_d = cnt_q;
        default: ;
      endcase
    end else if (step) begin
      if (wrap_up)         cnt_d = '0;
      else if (wrap_dn)    cnt_d = hw_copy ? per_buf : per_act;
      else if (flags.down) cnt_d = cnt_q - 1'b1;
      else                 cnt_d = cnt_q + 1'b1;
      if (wrap && flags.one_shot) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      snap_q <= '0;
    end else if (tick) begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      snap_q <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= wrap_up;
      unf_q <= wrap_dn;
    end
  end

  assign snap    = snap_q;
  assign running = run_q;
  assign ovf_evt = ovf_q;
  assign unf_evt = unf_q;

  // R4
  restart_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_RESTART) |=> run_q);

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_HALT) |=> (!run_q && $stable(cnt_q)));

  // R8
  one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && flags.one_shot) |=> !run_q);

  // R12
  cmd_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> (!ovf_q && !unf_q));

  // R6
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_q && unf_q));

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && op == OP_SNAP) |=> $stable(snap_q));

endmodule

// File: rtl/cmd_timer.sv
`timescale 1ns/100ps
module cmd_timer
  import cmd_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] PER_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic              capture_en,
  output logic              ovf_evt,
  output logic              unf_evt,
  output logic              running
);

  localparam int unsigned OP_W = 3;

  tmr_flags_t        flags;
  logic [OP_W-1:0]   op_pend;
  logic              copy;
  logic [DATA_W-1:0] per_buf, cmp_buf, per_act, cmp_act, snap;
  logic [DATA_W-1:0] ctrl_view;

  tmr_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (bus_we),
    .addr      (bus_addr),
    .flag_bits (bus_wdata[2:0]),
    .op_bits   (bus_wdata[OP_LSB +: OP_W]),
    .tick      (tick),
    .flags     (flags),
    .op_pend   (op_pend)
  );

  tmr_bufs #(.DATA_W(DATA_W), .PER_RST(PER_RST)) u_bufs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .copy    (copy),
    .per_buf (per_buf),
    .cmp_buf (cmp_buf),
    .per_act (per_act),
    .cmp_act (cmp_act)
  );

  tmr_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .op         (op_pend),
    .flags      (flags),
    .capture_en (capture_en),
    .per_act    (per_act),
    .per_buf    (per_buf),
    .copy       (copy),
    .snap       (snap),
    .running    (running),
    .ovf_evt    (ovf_evt),
    .unf_evt    (unf_evt)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[2:0] = {flags.one_shot, flags.lock, flags.down};
    ctrl_view[OP_LSB +: OP_W] = op_pend;
  end

  always_comb begin
    case (bus_addr)
      ADR_SET, ADR_CLR: bus_rdata = ctrl_view;
      ADR_PBUF:         bus_rdata = per_buf;
      ADR_CBUF:         bus_rdata = cmp_buf;
      ADR_PER:          bus_rdata = per_act;
      ADR_CMP:          bus_rdata = cmp_act;
      ADR_SNAP:         bus_rdata = snap;
      default:          bus_rdata = '0;
    endcase
  end

  // R7
  evt_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt || unf_evt) |-> $past(running));

endmodule

// File: tb/cmd_timer_bench.sv
`timescale 1ns/100ps
module cmd_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tick;
  logic        capture_en;
  logic        ovf_evt, unf_evt, running;

  int n_checks = 0;
  int n_fails  = 0;

  // reference model state
  logic        m_dir, m_lock, m_os, m_run, m_ovf, m_unf;
  logic [2:0]  m_cmd;
  logic [15:0] m_cnt, m_per, m_cmp, m_pbuf, m_cbuf, m_snap;
  logic        cap_r;

  cmd_timer u_cmd_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .capture_en(capture_en), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .running(running)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int a);
    case (a)
      0: return "R2";
      1: return "R3";
      6: return "R11";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] exp_read(input int a);
    case (a)
      0, 1: return {9'b0, m_cmd, 1'b0, m_os, m_lock, m_dir};
      2: return m_pbuf;
      3: return m_cbuf;
      4: return m_per;
      5: return m_cmp;
      6: return m_snap;
      default: return 16'h0;
    endcase
  endfunction

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_we = 1'b0; tick = 1'b0; bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  task automatic check_all();
    bus_we = 1'b0; tick = 1'b0;
    chk("R5", {15'b0, running}, {15'b0, m_run});
    chk("R6", {15'b0, ovf_evt}, {15'b0, m_ovf});
    chk("R7", {15'b0, unf_evt}, {15'b0, m_unf});
    for (int a = 0; a < 7; a++) begin
      bus_addr = a[2:0];
      #0.2;
      chk(tag_of(a), bus_rdata, exp_read(a));
    end
  endtask

  task automatic model_step(input logic we, input logic [2:0] a, input logic [15:0] d, input logic tk);
    logic wrap, cp;
    m_ovf = 1'b0; m_unf = 1'b0;
    if (tk) begin
      if (m_cmd != 3'd0) begin
        case (m_cmd)
          3'd1: begin m_cnt = m_dir ? m_per : 16'h0; m_run = 1'b1; end
          3'd2: m_run = 1'b0;
          3'd3: begin m_per = m_pbuf; m_cmp = m_cbuf; end
          3'd4: m_snap = m_cnt;
          default: ;
        endcase
        m_cmd = 3'd0;
      end else if (m_run) begin
        wrap = 1'b0;
        if (!m_dir) begin
          if (m_cnt == m_per) begin wrap = 1'b1; m_ovf = 1'b1; m_cnt = 16'h0; end
          else m_cnt = m_cnt + 16'h1;
        end else if (m_cnt == 16'h0) begin
          wrap = 1'b1; m_unf = 1'b1;
        end else m_cnt = m_cnt - 16'h1;
        if (wrap) begin
          cp = !m_lock || cap_r;
          if (m_unf) m_cnt = cp ? m_pbuf : m_per;
          if (cp) begin m_per = m_pbuf; m_cmp = m_cbuf; end
          if (m_os) m_run = 1'b0;
        end
      end
    end
    if (we) begin
      case (a)
        3'd0: begin
          if (d[0]) m_dir = 1'b1;
          if (d[1]) m_lock = 1'b1;
          if (d[2]) m_os = 1'b1;
          if (d[6:4] != 3'd0) m_cmd = d[6:4];
        end
        3'd1: begin
          if (d[0]) m_dir = 1'b0;
          if (d[1]) m_lock = 1'b0;
          if (d[2]) m_os = 1'b0;
        end
        3'd2: m_pbuf = d;
        3'd3: m_cbuf = d;
        default: ;
      endcase
    end
  endtask

  task automatic do_cycle(input logic we, input logic [2:0] a, input logic [15:0] d, input logic tk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick = tk; capture_en = cap_r;
    @(posedge clk);
    model_step(we, a, d, tk);
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    do_cycle(1'b1, a, d, 1'b0);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) do_cycle(1'b0, 3'd0, 16'h0, 1'b1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [31:0] r;
    logic        we;
    logic [2:0]  a;
    logic [15:0] d;
    r = $urandom(32'd2024);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 3'd0; bus_wdata = 16'h0;
    tick = 1'b0; cap_r = 1'b0; capture_en = 1'b0;
    m_dir = 0; m_lock = 0; m_os = 0; m_run = 0; m_ovf = 0; m_unf = 0;
    m_cmd = 0; m_cnt = 0; m_per = 16'hFFFF; m_cmp = 0;
    m_pbuf = 16'hFFFF; m_cbuf = 0; m_snap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd4, v); chk("R1", v, 16'hFFFF);
    rd(3'd0, v); chk("R1", v, 16'h0000);
    rd(3'd6, v); chk("R1", v, 16'h0000);
    chk("R1", {15'b0, running}, 16'h0);
    check_all();

    // R2 / R10: post a forced load, pending until the tick
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h0030);
    rd(3'd0, v); chk("R2", v, 16'h0030);
    tk(1);
    rd(3'd4, v); chk("R10", v, 16'd3);
    rd(3'd0, v); chk("R2", v, 16'h0000);

    // R4 restart, R12 no event on command tick, R6 wrap
    wr(3'd0, 16'h0010);
    tk(1);
    chk("R4", {15'b0, running}, 16'h1);
    chk("R12", {15'b0, ovf_evt}, 16'h0);
    tk(4);
    chk("R6", {15'b0, ovf_evt}, 16'h1);

    // R8 one-shot stops at wrap
    wr(3'd0, 16'h0004);
    tk(4);
    chk("R8", {15'b0, running}, 16'h0);
    tk(2);

    // R7 down counting, R11 snapshot
    wr(3'd1, 16'h0004);
    wr(3'd0, 16'h0001);
    wr(3'd0, 16'h0010);
    tk(1);
    wr(3'd0, 16'h0040);
    tk(1);
    rd(3'd6, v); chk("R11", v, 16'd3);
    tk(4);
    chk("R7", {15'b0, unf_evt}, 16'h1);

    // R9 lock holds active period, capture overrides the lock
    wr(3'd0, 16'h0002);
    wr(3'd2, 16'd6);
    tk(4);
    rd(3'd4, v); chk("R9", v, 16'd3);
    cap_r = 1'b1;
    tk(4);
    rd(3'd4, v); chk("R9", v, 16'd6);
    cap_r = 1'b0;

    // R10 forced load ignores lock
    wr(3'd2, 16'd2);
    wr(3'd0, 16'h0030);
    tk(1);
    rd(3'd4, v); chk("R10", v, 16'd2);

    // R5 halt keeps count
    wr(3'd0, 16'h0020);
    tk(3);
    chk("R5", {15'b0, running}, 16'h0);

    // R3 zero writes change nothing, clear address clears flags
    wr(3'd0, 16'h0000);
    rd(3'd0, v); chk("R3", v, 16'h0003);
    wr(3'd1, 16'h0007);
    rd(3'd0, v); chk("R3", v, 16'h0000);

    // R2 post in the same cycle as a tick stays pending
    do_cycle(1'b1, 3'd0, 16'h0010, 1'b1);
    rd(3'd0, v); chk("R2", v, 16'h0010);
    tk(1);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      we = ($urandom % 4) == 0;
      a  = 3'($urandom % 4);
      case (a)
        3'd0: d = {9'b0, (($urandom % 2) == 0) ? 3'($urandom % 8) : 3'd0, 1'b0,
                   (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'd0};
        3'd1: d = 16'($urandom % 8);
        default: d = 16'($urandom % 12);
      endcase
      if (($urandom % 50) == 0) cap_r = ~cap_r;
      do_cycle(we, a, d, 1'(($urandom % 2) == 0));
    end
    finish_run();
  end

endmodule